// File: doc/BRIEF.md
# Auxiliary Core Reset-Hold Sequencer

This block sequences reset and power-on for one auxiliary processor core. Firmware reaches it through a simple register port with three registers. The first is a reset-trigger register whose written bits are set and stay set. The second is a reset-clear register that clears bits in the trigger register. The third is a per-core control/status register.

Toward the core, the block drives a run level and a one-cycle power-on-and-reset pulse. Inside, it keeps three status flags: the core is in reset, the core is held in reset, and an external reset source is pending. When firmware sets a hold request, the core stays parked after a reset. It starts only when the hold request is withdrawn or when a self-clearing enable strobe is written.

A write is taken on the rising clock edge when `wr_en` is high. A read is combinational from `rd_addr`. Register offsets are byte addresses. The control register sits at 0x120, the trigger register at 0x200 and the clear register at 0x204. The sequencing bit in the trigger and clear registers is bit 30. In the control register, bit 0 is the enable strobe and bit 1 is the hold request. Bits 7:2 are plain storage. Bit 8 is in-reset, bit 9 is held and bit 10 is source-pending.

Top module: `aux_rstseq`

## Requirements
- R1: After reset the control register reads 0x000007FE, the trigger register reads 0xFFC37FDC, `core_run` is 0 and `core_pon` is 0.
- R2: A write to the trigger register ORs the data into the stored value. When data bit 30 is 1, in-reset and source-pending are set and `core_run` falls. Held is set too if the stored hold request (bit 1) is 1. A write without bit 30 changes no status flag.
- R3: A write to the clear register clears the trigger bits where the data has a 1 and the stored bit is 1. The power-on routine runs only if bit 30 was cleared this way. The clear register reads 0.
- R4: The power-on routine always clears source-pending. If held is 0 after the write, it also clears in-reset and issues a `core_pon` pulse. If held is 1, the core stays in reset.
- R5: A control write that takes the hold request from 1 to 0 clears held. The power-on routine runs only if, before the write, in-reset was 1 and source-pending was 0.
- R6: Writing 1 to the enable bit clears held and runs the power-on routine, but only if, before the write, in-reset and held were 1 and source-pending was 0. Otherwise the strobe has no effect.
- R7: The enable bit is never stored and always reads 0.
- R8: A control write updates only bits 7:0. Bits 10:8 change only through sequencing, and bits 31:11 read 0.
- R9: `core_pon` is high for exactly one cycle. It rises in the same cycle as `core_run`, and `core_run` is high exactly while in-reset is 0.
- R10: A control write that releases the hold request and strobes enable together issues one `core_pon` pulse, not two.
- R11: Held is never 1 while in-reset is 0.
- R12: A write to any other offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| core_run | output | 1 | High while the core is out of reset |
| core_pon | output | 1 | One-cycle power-on-and-reset pulse |

## Verification
The checker assumes at most one register write per cycle and a clean, glitch-free `wr_en`. It also assumes that a trigger write with bit 30 set is the only way to put the core back into reset. Under those conditions, a pulse can never follow another pulse directly. The stimulus issues one write, or one idle cycle, per clock and drives inputs only at falling edges. It walks every path into and out of reset: automatic release, release of the hold request, the enable strobe, and the combined release-plus-enable write. It also covers strobes that must be ignored because a source is still pending or the core is already running.

// File: rtl/aux_rstseq_pkg.sv
package aux_rstseq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_TRIG = 2'd2,
      SEL_CLR  = 2'd3
   } reg_sel_t;

   typedef struct packed {
      logic src;    // external reset source pending
      logic hold;   // held in reset awaiting release
      logic inrst;  // core in reset
   } rst_status_t;

   localparam int unsigned STATUS_W = 3;

endpackage

// File: rtl/aux_rstseq_decode.sv
module aux_rstseq_decode
   import aux_rstseq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned CTRL_OFS = 'h120,
   parameter int unsigned TRIG_OFS = 'h200,
   parameter int unsigned CLR_OFS  = 'h204
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(TRIG_OFS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

   always_comb begin
      sel = SEL_NONE;
      if (en) begin
         if (addr == A_CTRL)      sel = SEL_CTRL;
         else if (addr == A_TRIG) sel = SEL_TRIG;
         else if (addr == A_CLR)  sel = SEL_CLR;
      end
   end

endmodule

// File: rtl/aux_rstseq_trigger.sv
module aux_rstseq_trigger #(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       SEQ_BIT  = 30,
   parameter logic [DATA_W-1:0] RST_VAL  = 32'hFFC3_7FDC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q,
   output logic              start_rst,
   output logic              clr_hit
);

   logic [DATA_W-1:0] clr_mask;

   assign clr_mask  = clr_en ? (wdata & q) : '0;
   assign start_rst = set_en & wdata[SEQ_BIT];
   assign clr_hit   = clr_mask[SEQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (set_en) q <= q | wdata;
      else if (clr_en) q <= q & ~clr_mask;
   end

endmodule

// File: rtl/aux_rstseq_seq.sv
module aux_rstseq_seq
   import aux_rstseq_pkg::*;
#(
   parameter int unsigned       CTRL_W   = 8,
   parameter int unsigned       EN_BIT   = 0,
   parameter int unsigned       REQ_BIT  = 1,
   parameter logic [CTRL_W-1:0] CTRL_RST = 8'hFE,
   parameter rst_status_t       STAT_RST = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rst,
   input  logic              clr_hit,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output rst_status_t       status,
   output logic              core_pon
);

   rst_status_t       st_n;
   logic [CTRL_W-1:0] ctrl_n;
   logic              pon_n;
   logic              power_on;
   logic              release_req;
   logic              strobe_ok;

   always_comb begin
      st_n        = status;
      ctrl_n      = ctrl_q;
      pon_n       = 1'b0;
      power_on    = 1'b0;
      release_req = 1'b0;
      strobe_ok   = 1'b0;
      if (start_rst) begin
         st_n.inrst = 1'b1;
         st_n.src   = 1'b1;
         if (ctrl_q[REQ_BIT]) st_n.hold = 1'b1;
      end else if (clr_hit) begin
         power_on = 1'b1;
      end else if (ctrl_we) begin
         release_req = ctrl_q[REQ_BIT] & ~ctrl_wdata[REQ_BIT];
         strobe_ok   = ctrl_wdata[EN_BIT] & status.inrst & status.hold & ~status.src;
         if (release_req) begin
            st_n.hold = 1'b0;
            if (status.inrst && !status.src) power_on = 1'b1;
         end
         if (strobe_ok) begin
            st_n.hold = 1'b0;
            power_on  = 1'b1;
         end
         ctrl_n         = ctrl_wdata;
         ctrl_n[EN_BIT] = 1'b0;
      end
      if (power_on) begin
         st_n.src = 1'b0;
         if (!st_n.hold) begin
            st_n.inrst = 1'b0;
            pon_n      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= STAT_RST;
         ctrl_q   <= CTRL_RST;
         core_pon <= 1'b0;
      end else begin
         status   <= st_n;
         ctrl_q   <= ctrl_n;
         core_pon <= pon_n;
      end
   end

endmodule

// File: rtl/aux_rstseq.sv
module aux_rstseq
   import aux_rstseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTRL_OFS  = 'h120,
   parameter int unsigned TRIG_OFS  = 'h200,
   parameter int unsigned CLR_OFS   = 'h204,
   parameter int unsigned SEQ_BIT   = 30,
   parameter int unsigned CTRL_W    = 8,
   parameter int unsigned EN_BIT    = 0,
   parameter int unsigned REQ_BIT   = 1,
   parameter int unsigned STAT_LSB  = 8,
   parameter logic [31:0] TRIG_RST  = 32'hFFC3_7FDC,
   parameter logic [31:0] CTRL_RST  = 32'h0000_07FE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              core_run,
   output logic              core_pon
);

   localparam int unsigned STAT_MSB = STAT_LSB + STATUS_W - 1;
   localparam logic [CTRL_W-1:0] CTRL_LOW_RST = CTRL_RST[CTRL_W-1:0];
   localparam rst_status_t       STAT_RST     = CTRL_RST[STAT_MSB:STAT_LSB];

   if (DATA_W < 32 || DATA_W > 64) begin : g_bad_width
      $error("aux_rstseq: DATA_W must lie in 32..64");
   end
   if (SEQ_BIT >= DATA_W) begin : g_bad_seq
      $error("aux_rstseq: SEQ_BIT outside data word");
   end
   if (EN_BIT >= CTRL_W || REQ_BIT >= CTRL_W || EN_BIT == REQ_BIT) begin : g_bad_ctrl
      $error("aux_rstseq: control bit positions invalid");
   end
   if (STAT_LSB < CTRL_W || STAT_MSB >= DATA_W) begin : g_bad_stat
      $error("aux_rstseq: status field overlaps or overflows");
   end

   reg_sel_t          wr_sel;
   reg_sel_t          rd_sel;
   logic [DATA_W-1:0] trig_q;
   logic              start_rst;
   logic              clr_hit;
   logic [CTRL_W-1:0] ctrl_low;
   rst_status_t       status;
   logic              st_inrst;
   logic              st_hold;
   logic              st_src;
   logic [DATA_W-1:0] ctrl_word;

   aux_rstseq_decode #(
      .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .TRIG_OFS(TRIG_OFS), .CLR_OFS(CLR_OFS)
   ) u_wr_dec (
      .en(wr_en), .addr(wr_addr), .sel(wr_sel)
   );

   aux_rstseq_decode #(
      .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .TRIG_OFS(TRIG_OFS), .CLR_OFS(CLR_OFS)
   ) u_rd_dec (
      .en(1'b1), .addr(rd_addr), .sel(rd_sel)
   );

   aux_rstseq_trigger #(
      .DATA_W(DATA_W), .SEQ_BIT(SEQ_BIT), .RST_VAL(DATA_W'(TRIG_RST))
   ) u_trig (
      .clk(clk), .rst_n(rst_n),
      .set_en(wr_sel == SEL_TRIG), .clr_en(wr_sel == SEL_CLR),
      .wdata(wr_data), .q(trig_q),
      .start_rst(start_rst), .clr_hit(clr_hit)
   );

   aux_rstseq_seq #(
      .CTRL_W(CTRL_W), .EN_BIT(EN_BIT), .REQ_BIT(REQ_BIT),
      .CTRL_RST(CTRL_LOW_RST), .STAT_RST(STAT_RST)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_rst(start_rst), .clr_hit(clr_hit),
      .ctrl_we(wr_sel == SEL_CTRL), .ctrl_wdata(wr_data[CTRL_W-1:0]),
      .ctrl_q(ctrl_low), .status(status), .core_pon(core_pon)
   );

   assign st_inrst = status.inrst;
   assign st_hold  = status.hold;
   assign st_src   = status.src;
   assign core_run = ~status.inrst;

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[CTRL_W-1:0]        = ctrl_low;
      ctrl_word[STAT_MSB:STAT_LSB] = status;
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL: rd_data = ctrl_word;
         SEL_TRIG: rd_data = trig_q;
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/aux_rstseq_chk.sv
module aux_rstseq_chk #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TRIG_OFS = 'h200,
   parameter int unsigned SEQ_BIT  = 30,
   parameter int unsigned CTRL_W   = 8,
   parameter int unsigned EN_BIT   = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              core_run,
   input logic              core_pon,
   input logic              st_inrst,
   input logic              st_hold,
   input logic              st_src,
   input logic [CTRL_W-1:0] ctrl_low
);

   logic trig_start;
   assign trig_start = wr_en && (wr_addr == ADDR_W'(TRIG_OFS)) && wr_data[SEQ_BIT];

   assert_pon_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_pon |=> !core_pon);

   assert_pon_with_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_pon |-> core_run);

   assert_run_rise_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_run) |-> core_pon);

   assert_hold_in_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      st_hold |-> st_inrst);

   assert_status_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({st_src, st_hold, st_inrst}));

   assert_trigger_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_start |=> (!core_run && st_inrst && st_src));

   assert_enable_unstored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_low[EN_BIT]);

endmodule

bind aux_rstseq aux_rstseq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_OFS(TRIG_OFS),
   .SEQ_BIT(SEQ_BIT), .CTRL_W(CTRL_W), .EN_BIT(EN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .core_run(core_run), .core_pon(core_pon),
   .st_inrst(st_inrst), .st_hold(st_hold), .st_src(st_src), .ctrl_low(ctrl_low)
);

// File: tb/aux_rstseq_tb.sv
`timescale 1ns/100ps
module aux_rstseq_tb;

   localparam logic [11:0] A_CTRL = 12'h120;
   localparam logic [11:0] A_TRIG = 12'h200;
   localparam logic [11:0] A_CLR  = 12'h204;
   localparam logic [31:0] B30    = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = 12'h120;
   logic [31:0] rd_data;
   logic        core_run;
   logic        core_pon;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [11:0] q_addr[$];
   logic [31:0] q_data[$];
   logic        q_run[$];
   logic        q_pon[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   aux_rstseq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .core_run(core_run), .core_pon(core_pon)
   );

   // driver: one write or idle cycle per clock, expected view after that edge queued
   task automatic step(input logic we, input logic [11:0] wa, input logic [31:0] wd,
                       input logic [11:0] ra, input logic [31:0] erd,
                       input logic erun, input logic epon, input string tag);
      @(negedge clk);
      wr_en   = we;
      wr_addr = wa;
      wr_data = wd;
      q_addr.push_back(ra);
      q_data.push_back(erd);
      q_run.push_back(erun);
      q_pon.push_back(epon);
      q_tag.push_back(tag);
      @(posedge clk);
      #0.2 wr_en = 1'b0;
   endtask

   task automatic idle(input logic [11:0] ra, input logic [31:0] erd,
                       input logic erun, input logic epon, input string tag);
      step(1'b0, 12'h000, 32'h0, ra, erd, erun, epon, tag);
   endtask

   // monitor: compares outputs just after each edge
   initial begin
      forever begin
         @(posedge clk);
         #0.5;
         if (q_addr.size() > 0) begin
            logic [31:0] ed;
            logic er, ep;
            string t;
            rd_addr = q_addr.pop_front();
            ed = q_data.pop_front();
            er = q_run.pop_front();
            ep = q_pon.pop_front();
            t  = q_tag.pop_front();
            #0.5;
            vectors++;
            if (rd_data !== ed || core_run !== er || core_pon !== ep) begin
               miscompares++;
               $display("FAIL %s: rd_data=%h exp %h, core_run=%b exp %b, core_pon=%b exp %b",
                        t, rd_data, ed, core_run, er, core_pon, ep);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset view
      idle(A_CTRL, 32'h0000_07FE, 1'b0, 1'b0, "R1 ctrl reset");
      idle(A_TRIG, 32'hFFC3_7FDC, 1'b0, 1'b0, "R1 trigger reset");
      idle(A_CLR,  32'h0,         1'b0, 1'b0, "R3 clear reads zero");
      // R3 clear of pending bit 30, hold keeps core parked (R4)
      step(1'b1, A_CLR, B30, A_TRIG, 32'hBFC3_7FDC, 1'b0, 1'b0, "R3 clear bit30");
      idle(A_CTRL, 32'h0000_03FE, 1'b0, 1'b0, "R4 held stays in reset");
      step(1'b1, A_CLR, B30, A_CTRL, 32'h0000_03FE, 1'b0, 1'b0, "R3 clear of unset bit ignored");
      // R8 high bits of control write ignored
      step(1'b1, A_CTRL, 32'hFFFF_F8FE, A_CTRL, 32'h0000_03FE, 1'b0, 1'b0, "R8 status untouched");
      // R6 enable strobe releases
      step(1'b1, A_CTRL, 32'h0000_00FF, A_CTRL, 32'h0000_00FE, 1'b1, 1'b1, "R6 enable release");
      idle(A_CTRL, 32'h0000_00FE, 1'b1, 1'b0, "R9 pulse one cycle");
      // R2 trigger with hold request set
      step(1'b1, A_TRIG, B30, A_CTRL, 32'h0000_07FE, 1'b0, 1'b0, "R2 trigger with hold req");
      idle(A_TRIG, 32'hFFC3_7FDC, 1'b0, 1'b0, "R2 trigger bits ORed");
      step(1'b1, A_TRIG, 32'h1, A_TRIG, 32'hFFC3_7FDD, 1'b0, 1'b0, "R2 OR other bit");
      idle(A_CTRL, 32'h0000_07FE, 1'b0, 1'b0, "R2 no status change without bit30");
      // R5 release while source pending: no power-on; R6 strobe blocked
      step(1'b1, A_CTRL, 32'h0000_0001, A_CTRL, 32'h0000_0500, 1'b0, 1'b0, "R5 release with source pending");
      // R4 clear runs power-on, no hold
      step(1'b1, A_CLR, 32'h4000_0001, A_CTRL, 32'h0000_0000, 1'b1, 1'b1, "R4 power-on after clear");
      idle(A_TRIG, 32'hBFC3_7FDC, 1'b1, 1'b0, "R3 only set bits cleared");
      // automatic path without hold
      step(1'b1, A_TRIG, B30, A_CTRL, 32'h0000_0500, 1'b0, 1'b0, "R2 trigger without hold req");
      step(1'b1, A_CLR, B30, A_CTRL, 32'h0000_0000, 1'b1, 1'b1, "R4 automatic power-on");
      // R5 release of hold request powers on
      step(1'b1, A_CTRL, 32'h0000_0002, A_CTRL, 32'h0000_0002, 1'b1, 1'b0, "R8 low byte written");
      step(1'b1, A_TRIG, B30, A_CTRL, 32'h0000_0702, 1'b0, 1'b0, "R11 held and in reset");
      step(1'b1, A_CLR, B30, A_CTRL, 32'h0000_0302, 1'b0, 1'b0, "R4 clear while held");
      step(1'b1, A_CTRL, 32'h0000_0000, A_CTRL, 32'h0000_0000, 1'b1, 1'b1, "R5 release powers on");
      idle(A_CTRL, 32'h0000_0000, 1'b1, 1'b0, "R9 pulse drops");
      // R10 release and enable together
      step(1'b1, A_CTRL, 32'h0000_0002, A_CTRL, 32'h0000_0002, 1'b1, 1'b0, "R10 setup req");
      step(1'b1, A_TRIG, B30, A_CTRL, 32'h0000_0702, 1'b0, 1'b0, "R10 setup trigger");
      step(1'b1, A_CLR, B30, A_CTRL, 32'h0000_0302, 1'b0, 1'b0, "R10 setup clear");
      step(1'b1, A_CTRL, 32'h0000_0001, A_CTRL, 32'h0000_0000, 1'b1, 1'b1, "R10 combined write");
      idle(A_CTRL, 32'h0000_0000, 1'b1, 1'b0, "R10 single pulse");
      // R6 strobe while running ignored, R7 enable not stored
      step(1'b1, A_CTRL, 32'h0000_0001, A_CTRL, 32'h0000_0000, 1'b1, 1'b0, "R6 strobe while running");
      step(1'b1, A_CTRL, 32'h0000_0003, A_CTRL, 32'h0000_0002, 1'b1, 1'b0, "R7 enable reads zero");
      // R12 unmapped write
      step(1'b1, 12'h300, 32'hFFFF_FFFF, A_CTRL, 32'h0000_0002, 1'b1, 1'b0, "R12 unmapped write ctrl");
      idle(A_TRIG, 32'hBFC3_7FDC, 1'b1, 1'b0, "R12 unmapped write trigger");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule